// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the status and control word of a floating-point unit. Each time the arithmetic datapath finishes an operation, it presents a five-bit set of raw exception indications. The block then rewrites the per-operation cause field from that set and ORs the same bits into a sticky flag field. When any fresh cause meets its enable bit, the block pulses a trap request for one cycle. The trap request carries a fixed exception vector offset.

Software loads the whole word through a fixed write mask, so reserved positions always read as zero. Two fields of the stored word drive the datapath. The two-bit mode field picks round-toward-zero or round-to-nearest-even, and a denormal-control bit drives flush-to-zero. An operation tagged as approximate (for example a reciprocal square-root estimate) reports inexact when it raised nothing else.

Exception classes use the same bit index in the raw input, the cause field, the flag field and the enable field: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The status word is laid out as flags [4:0], enables [9:5], causes [14:10], mode [17:16] and denormal control [20]. All other bits are reserved.

Top module: `fp_status_unit`

## Requirements
- R1: After reset, `csr_value` is 0, `trap_req` is 0, `round_to_zero` is 0 and `flush_zero` is 0.
- R2: An accepted operation (`op_done` high, `sw_wr_en` low) replaces the cause field [14:10] with the operation's cause set. Raw bit i maps to cause bit 10+i, in the class order bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid.
- R3: An accepted operation ORs its cause set into the flag field [4:0]. Flags are never cleared except by a software write.
- R4: One cycle after an accepted operation whose cause set ANDed with the enable field [9:5] is nonzero, `trap_req` is high for exactly that cycle. Otherwise it stays low. `trap_vector` is always 0x120.
- R5: A software write stores `sw_wr_data & 32'h0013_7FFF`, so reserved bits read as zero.
- R6: `round_to_zero` is 1 exactly when mode field [17:16] holds 2'b01. The encodings 2'b00, 2'b10 and 2'b11 give 0, which means round-to-nearest-even.
- R7: `flush_zero` equals bit 20 of the stored word.
- R8: An accepted operation with `op_approx` high and a raw set of zero records cause 5'b00001 (inexact). With any raw bit set, the raw set is recorded unchanged.
- R9: An accepted operation with no raw exception and `op_approx` low clears the cause field, leaves the flags unchanged and raises no trap.
- R10: When `sw_wr_en` and `op_done` are high in the same cycle, the write is stored, the operation is discarded and no trap is raised.
- R11: With neither `op_done` nor `sw_wr_en` high, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | An arithmetic operation completed this cycle |
| op_raw_exc | input | 5 | Raw exception set of that operation |
| op_approx | input | 1 | The operation is an approximate-result kind |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| csr_value | output | 32 | Stored status word |
| round_to_zero | output | 1 | 1: round toward zero, 0: round to nearest even |
| flush_zero | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_vector | output | 12 | Exception vector offset of the trap |

## Verification
The assertions assume that `op_done`, `op_approx`, `op_raw_exc`, `sw_wr_en` and `sw_wr_data` are known and stable around each rising edge. They also assume that the inputs change only while reset is released. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. This keeps every stimulus within those assumptions. Back-to-back operations, and a write that coincides with an operation, are produced on purpose, because the sticky-flag and write-priority checks must hold across them.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

  localparam int EXC_W     = 5;
  localparam int CSR_W     = 32;
  localparam int FLAG_LSB  = 0;
  localparam int EN_LSB    = 5;
  localparam int CAUSE_LSB = 10;
  localparam int MODE_LSB  = 16;
  localparam int MODE_W    = 2;
  localparam int DN_BIT    = 20;

  localparam logic [MODE_W-1:0] MODE_RTZ = 2'b01;

  typedef enum int {
    EXC_INEXACT   = 0,
    EXC_UNDERFLOW = 1,
    EXC_OVERFLOW  = 2,
    EXC_DIVZERO   = 3,
    EXC_INVALID   = 4
  } exc_idx_e;

  typedef logic [EXC_W-1:0] exc_set_t;

  // Mask of all storable bits in the status word.
  function automatic logic [CSR_W-1:0] f_write_mask();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < EXC_W; i++) begin
      m[FLAG_LSB + i]  = 1'b1;
      m[EN_LSB + i]    = 1'b1;
      m[CAUSE_LSB + i] = 1'b1;
    end
    for (int i = 0; i < MODE_W; i++) m[MODE_LSB + i] = 1'b1;
    m[DN_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [CSR_W-1:0] WR_MASK = f_write_mask();

  // Cause set of one operation: an approximate result with nothing
  // else reported is marked inexact.
  function automatic exc_set_t f_cause(exc_set_t raw, logic approx);
    exc_set_t c;
    c = raw;
    if (approx && (raw == '0)) c[EXC_INEXACT] = 1'b1;
    return c;
  endfunction

  function automatic logic f_trap_hit(exc_set_t cause, exc_set_t enable);
    return |(cause & enable);
  endfunction

  function automatic exc_set_t f_accumulate(exc_set_t flags, exc_set_t cause);
    return flags | cause;
  endfunction

endpackage

// File: rtl/fp_cause_gen.sv
module fp_cause_gen
  import fp_status_pkg::*;
(
  input  logic     [EXC_W-1:0] raw_exc,
  input  logic                 approx,
  output logic     [EXC_W-1:0] cause
);
  always_comb cause = f_cause(raw_exc, approx);
endmodule

// File: rtl/fp_mode_decode.sv
module fp_mode_decode
  import fp_status_pkg::*;
(
  input  logic [MODE_W-1:0] mode_field,
  input  logic              dn_bit,
  output logic              round_to_zero,
  output logic              flush_zero
);
  always_comb begin
    round_to_zero = (mode_field == MODE_RTZ);
    flush_zero    = dn_bit;
  end
endmodule

// File: rtl/fp_status_store.sv
module fp_status_store
  import fp_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             op_accept,
  input  logic [EXC_W-1:0] new_cause,
  output logic [CSR_W-1:0] csr,
  output logic             trap_req
);
  logic [EXC_W-1:0] flags_q, enable_q, cause_q;
  logic             trap_hit;

  assign flags_q  = csr[FLAG_LSB  +: EXC_W];
  assign enable_q = csr[EN_LSB    +: EXC_W];
  assign cause_q  = csr[CAUSE_LSB +: EXC_W];
  assign trap_hit = f_trap_hit(new_cause, enable_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr      <= '0;
      trap_req <= 1'b0;
    end else if (wr_en) begin
      csr      <= wr_data & WR_MASK;
      trap_req <= 1'b0;
    end else if (op_accept) begin
      csr[CAUSE_LSB +: EXC_W] <= new_cause;
      csr[FLAG_LSB  +: EXC_W] <= f_accumulate(flags_q, new_cause);
      trap_req                <= trap_hit;
    end else begin
      trap_req <= 1'b0;
    end
  end

  logic unused_cause;
  assign unused_cause = ^cause_q;
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fp_status_pkg::*;
#(
  parameter int                TRAP_W      = 12,
  parameter logic [TRAP_W-1:0] TRAP_OFFSET = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [EXC_W-1:0]  op_raw_exc,
  input  logic              op_approx,
  input  logic              sw_wr_en,
  input  logic [CSR_W-1:0]  sw_wr_data,
  output logic [CSR_W-1:0]  csr_value,
  output logic              round_to_zero,
  output logic              flush_zero,
  output logic              trap_req,
  output logic [TRAP_W-1:0] trap_vector
);
  // Named internal events, visible to the bound checker.
  logic             op_accept;
  logic [EXC_W-1:0] next_cause;

  assign op_accept   = op_done && !sw_wr_en;
  assign trap_vector = TRAP_OFFSET;

  fp_cause_gen u_cause (
    .raw_exc (op_raw_exc),
    .approx  (op_approx),
    .cause   (next_cause)
  );

  fp_status_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en),
    .wr_data   (sw_wr_data),
    .op_accept (op_accept),
    .new_cause (next_cause),
    .csr       (csr_value),
    .trap_req  (trap_req)
  );

  fp_mode_decode u_mode (
    .mode_field    (csr_value[MODE_LSB +: MODE_W]),
    .dn_bit        (csr_value[DN_BIT]),
    .round_to_zero (round_to_zero),
    .flush_zero    (flush_zero)
  );
endmodule

// File: rtl/fp_status_unit_checker.sv
module fp_status_unit_checker
  import fp_status_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_done,
  input logic [EXC_W-1:0] op_raw_exc,
  input logic             op_approx,
  input logic             sw_wr_en,
  input logic [CSR_W-1:0] sw_wr_data,
  input logic [CSR_W-1:0] csr_value,
  input logic             trap_req,
  input logic             op_accept
);
  a_r9_clean_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && op_raw_exc == '0 && !op_approx) |=>
      (csr_value[CAUSE_LSB +: EXC_W] == '0 && !trap_req));

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> (($past(csr_value[FLAG_LSB +: EXC_W]) & ~csr_value[FLAG_LSB +: EXC_W]) == '0));

  a_r4_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_accept));

  a_r4_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !op_accept) |=> !trap_req);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_value & ~WR_MASK) == '0);

  a_r8_approx_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && op_approx && op_raw_exc == '0) |=>
      (csr_value[CAUSE_LSB +: EXC_W] == 5'b00001));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (csr_value == ($past(sw_wr_data) & WR_MASK) && !trap_req));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !sw_wr_en) |=> $stable(csr_value));
endmodule

bind fp_status_unit fp_status_unit_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_done    (op_done),
  .op_raw_exc (op_raw_exc),
  .op_approx  (op_approx),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .csr_value  (csr_value),
  .trap_req   (trap_req),
  .op_accept  (op_accept)
);

// File: tb/fp_status_unit_test.sv
`timescale 1ns/1ps
module fp_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic [4:0]  op_raw_exc = '0;
  logic        op_approx = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] csr_value;
  logic        round_to_zero, flush_zero, trap_req;
  logic [11:0] trap_vector;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_status_unit uut (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_raw_exc(op_raw_exc),
    .op_approx(op_approx), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .csr_value(csr_value), .round_to_zero(round_to_zero),
    .flush_zero(flush_zero), .trap_req(trap_req), .trap_vector(trap_vector)
  );

  // {enable[4:0], raw[4:0], approx, expected cause[4:0], expected trap}
  localparam logic [16:0] VEC [0:9] = '{
    {5'b00000, 5'b00000, 1'b0, 5'b00000, 1'b0},
    {5'b11111, 5'b00000, 1'b0, 5'b00000, 1'b0},
    {5'b00000, 5'b10000, 1'b0, 5'b10000, 1'b0},
    {5'b10000, 5'b10000, 1'b0, 5'b10000, 1'b1},
    {5'b01000, 5'b10001, 1'b0, 5'b10001, 1'b0},
    {5'b00001, 5'b00000, 1'b1, 5'b00001, 1'b1},
    {5'b00001, 5'b00100, 1'b1, 5'b00100, 1'b0},
    {5'b00100, 5'b00110, 1'b1, 5'b00110, 1'b1},
    {5'b11111, 5'b11111, 1'b0, 5'b11111, 1'b1},
    {5'b00010, 5'b00010, 1'b0, 5'b00010, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic sw_write(logic [31:0] d);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk); sw_wr_en = 1'b0;
  endtask

  task automatic do_op(logic [4:0] raw, logic approx);
    @(negedge clk); op_done = 1'b1; op_raw_exc = raw; op_approx = approx;
    @(negedge clk); op_done = 1'b0; op_raw_exc = '0; op_approx = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csr", csr_value, 32'h0);
    check("R1 trap", {31'd0, trap_req}, 32'd0);
    check("R1 rtz", {31'd0, round_to_zero}, 32'd0);
    check("R1 flush", {31'd0, flush_zero}, 32'd0);
    check("R4 vector", {20'd0, trap_vector}, 32'h120);

    // Vector walk: R2 R3 R4 R8
    for (int i = 0; i < 10; i++) begin
      sw_write({22'd0, VEC[i][16:12], 5'd0});
      do_op(VEC[i][11:7], VEC[i][6]);
      check("R2 cause", {27'd0, csr_value[14:10]}, {27'd0, VEC[i][5:1]});
      check("R3 flags", {27'd0, csr_value[4:0]}, {27'd0, VEC[i][5:1]});
      check("R4 trap", {31'd0, trap_req}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check("R4 pulse end", {31'd0, trap_req}, 32'd0);
    end

    // R5 write mask
    sw_write(32'hFFFF_FFFF);
    check("R5 mask", csr_value, 32'h0013_7FFF);

    // R6 / R7 mode decode
    sw_write(32'h0001_0000);
    check("R6 mode01", {31'd0, round_to_zero}, 32'd1);
    sw_write(32'h0002_0000);
    check("R6 mode10", {31'd0, round_to_zero}, 32'd0);
    sw_write(32'h0003_0000);
    check("R6 mode11", {31'd0, round_to_zero}, 32'd0);
    check("R7 flush off", {31'd0, flush_zero}, 32'd0);
    sw_write(32'h0010_0000);
    check("R6 mode00", {31'd0, round_to_zero}, 32'd0);
    check("R7 flush on", {31'd0, flush_zero}, 32'd1);

    // R3 / R9 sticky flags across a clean op, accumulation
    sw_write(32'h0);
    do_op(5'b00100, 1'b0);
    do_op(5'b00000, 1'b0);
    check("R9 cause cleared", {27'd0, csr_value[14:10]}, 32'd0);
    check("R9 flags kept", {27'd0, csr_value[4:0]}, 32'b00100);
    check("R9 no trap", {31'd0, trap_req}, 32'd0);
    do_op(5'b00001, 1'b0);
    check("R3 accumulate", {27'd0, csr_value[4:0]}, 32'b00101);

    // R4 back-to-back trapping operations
    sw_write(32'h0000_03E0);
    @(negedge clk); op_done = 1'b1; op_raw_exc = 5'b01000;
    @(negedge clk); op_raw_exc = 5'b00000; op_approx = 1'b1;
    check("R4 first", {31'd0, trap_req}, 32'd1);
    @(negedge clk); op_done = 1'b0; op_approx = 1'b0;
    check("R4 second", {31'd0, trap_req}, 32'd1);
    check("R8 inexact", {27'd0, csr_value[14:10]}, 32'b00001);
    @(negedge clk);
    check("R4 drop", {31'd0, trap_req}, 32'd0);

    // R10 write and op same cycle
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = 32'h0000_03E0;
    op_done = 1'b1; op_raw_exc = 5'b11111;
    @(negedge clk); sw_wr_en = 1'b0; op_done = 1'b0; op_raw_exc = '0;
    check("R10 write kept", csr_value, 32'h0000_03E0);
    check("R10 no trap", {31'd0, trap_req}, 32'd0);

    // R11 idle hold
    repeat (4) @(negedge clk);
    check("R11 hold", csr_value, 32'h0000_03E0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule